// File: doc/BRIEF.md
# Segment-Mapped Three-Leg Center-Aligned PWM

This block drives the six switches of a three-leg bridge from a symmetric up/down carrier. Each period it takes three signed line-to-line duty commands, a segment number and a modulation mode. From these it picks one leg to park, works out the upper-switch duty of the two remaining legs, clamps those duties into a programmable band, and produces complementary gate pairs with a programmable dead time. Once per period, at the top of the carrier, it raises a one-cycle strobe that starts the current and voltage conversions. That instant lies in the middle of every upper-switch on-window.

All commands pass through shadow registers that are loaded in the last cycle of a carrier period. A new segment or duty therefore never takes effect halfway through a period. Three mappings are supported: 60-degree sectors (six segments), and 120-degree sectors referenced either to the upper or to the lower voltage envelope (three segments each).

Top module: `pwm3_seg_bridge`

## Requirements
- R1: The carrier phase runs through 2*PEAK cycles per period. It rises from 0 to PEAK-1, then falls from PEAK to 1, so trigger strobes are exactly 2*PEAK cycles apart.
- R2: `adc_trig_o` is high for one cycle per period, in the cycle where the carrier equals PEAK. After reset the first strobe comes in the PEAK-th cycle after reset release.
- R3: Mode and segment select the parked leg and its level, with legs numbered a=0, b=1, c=2. Mode 0 (60-degree): segments 0..5 park a-high, c-low, b-high, a-low, c-high, b-low. Mode 1 (upper envelope): segment s parks leg s high. Mode 2 (lower envelope): segments 0..2 park c, a, b low.
- R4: With the parked leg at level L (PEAK for high, 0 for low), the active upper duties are as follows. If a is parked: b=L-dab and c=L+dca. If b is parked: a=L+dab and c=L-dbc. If c is parked: b=L+dbc and a=L-dca.
- R5: Each active upper duty Dp is clamped into [duty_min_i, duty_max_i]. The bottom duty is Dn = PEAK-Dp.
- R6: In steady state an active leg turns its lower gate on 2*Dn-DT cycles per period and its upper gate on 2*Dp-DT cycles, where DT is the dead time. The lower gate turns on Dp+1+DT cycles after the strobe cycle.
- R7: The gate that turns on is held off for DT cycles after the other gate turns off, and the two gates of a leg are never on together.
- R8: Both gates of the parked leg stay off for the whole period.
- R9: Mode 3, a segment above 5 in mode 0, or a segment above 2 in modes 1 and 2 turn all six gates off.
- R10: Mode, segment, duties, limits and dead time are captured in the last cycle of a period. A change made after the strobe has no effect on the gates until the next period begins.
- R11: While reset is asserted all gates and the strobe are low. All gates stay low through the first period after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Modulation mode (0 60-degree, 1 upper envelope, 2 lower envelope, 3 off) |
| seg_i | input | 3 | Segment number from the segment detector |
| dab_i | input | DW | Signed a-to-b duty command in carrier counts |
| dbc_i | input | DW | Signed b-to-c duty command in carrier counts |
| dca_i | input | DW | Signed c-to-a duty command in carrier counts |
| duty_min_i | input | clog2(PEAK+1) | Lowest allowed active upper duty |
| duty_max_i | input | clog2(PEAK+1) | Highest allowed active upper duty |
| dead_i | input | DT_W | Dead time in clock cycles |
| gate_hi_o | output | 3 | Upper-switch gates, bit 0 is leg a |
| gate_lo_o | output | 3 | Lower-switch gates, bit 0 is leg a |
| adc_trig_o | output | 1 | Conversion strobe at carrier peak |

## Verification
The sweep visits every valid mode and segment pair with four duty triples. One triple sits inside the band, two straddle it so that the clamp engages at both ends, and the all-zero triple pushes every active leg against a limit. The dead time rises with the triple index, so a wrong mapping shows up as a wrong parked leg or on-count, a wrong clamp as a wrong lower count, and a wrong dead time or alignment as a shifted lower-gate turn-on. Reserved codes test the all-off path. A segment change issued right after the strobe separates capture at the period boundary from immediate use.

// File: rtl/pwm3_pkg.sv
// Shared encodings for the segment-mapped three-leg PWM.
// Assumes: leg indices 0,1,2 stand for legs a,b,c throughout the block.
package pwm3_pkg;
    typedef enum logic [1:0] {
        MODE_SIXTY   = 2'd0,
        MODE_UP_ENV  = 2'd1,
        MODE_LOW_ENV = 2'd2,
        MODE_OFF     = 2'd3
    } pwm_mode_e;

    localparam logic [1:0] LEG_A = 2'd0;
    localparam logic [1:0] LEG_B = 2'd1;
    localparam logic [1:0] LEG_C = 2'd2;
endpackage

// File: rtl/pwm3_carrier.sv
// Up/down carrier phase counter with peak strobe and period-end load pulse.
// Assumes: PEAK >= 2; the phase value maps to a triangle in the leg modules.
module pwm3_carrier #(
    parameter  int PEAK = 2500,
    localparam int PH_W = $clog2(2 * PEAK)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph_o,
    output logic            load_o,
    output logic            trig_o
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * PEAK - 1);
    localparam logic [PH_W-1:0] PH_PRE  = PH_W'(PEAK - 1);
    localparam logic [PH_W-1:0] PH_TOP  = PH_W'(PEAK);

    // Advance the phase and wrap at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_o <= '0;
        end else if (ph_o == PH_LAST) begin
            ph_o <= '0;
        end else begin
            ph_o <= ph_o + 1'b1;
        end
    end

    // Register the strobe so that it is high exactly in the peak cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o <= 1'b0;
        end else begin
            trig_o <= (ph_o == PH_PRE);
        end
    end

    // Shadow load request in the final cycle of each period.
    always_comb begin
        load_o = (ph_o == PH_LAST);
    end

    assert_trig_at_peak_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (ph_o == PH_TOP));

    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_o == PH_LAST) |=> (ph_o == '0));
endmodule

// File: rtl/pwm3_seg_map.sv
// Maps line-to-line duty commands to clamped per-leg bottom duties.
// Assumes: inputs are already captured in shadow registers; lo_lim <= hi_lim <= PEAK.
module pwm3_seg_map
    import pwm3_pkg::*;
#(
    parameter  int PEAK  = 2500,
    parameter  int DW    = 14,
    localparam int CNT_W = $clog2(PEAK + 1)
) (
    input  pwm_mode_e                mode_i,
    input  logic [2:0]               seg_i,
    input  logic signed [DW-1:0]     dab_i,
    input  logic signed [DW-1:0]     dbc_i,
    input  logic signed [DW-1:0]     dca_i,
    input  logic [CNT_W-1:0]         lo_lim_i,
    input  logic [CNT_W-1:0]         hi_lim_i,
    output logic [2:0]               en_o,
    output logic [2:0][CNT_W-1:0]    dn_o
);
    localparam int XW = DW + 2;

    logic [1:0]           park_leg;
    logic                 park_high;
    logic                 valid;
    logic signed [XW-1:0] lvl;
    logic signed [XW-1:0] ab;
    logic signed [XW-1:0] bc;
    logic signed [XW-1:0] ca;
    logic signed [XW-1:0] lo_s;
    logic signed [XW-1:0] hi_s;
    logic signed [XW-1:0] dp_raw [3];
    logic signed [XW-1:0] dp_cl  [3];

    // Select the parked leg and its level from mode and segment.
    always_comb begin
        park_leg  = LEG_A;
        park_high = 1'b0;
        valid     = 1'b0;
        case (mode_i)
            MODE_SIXTY: begin
                valid = (seg_i <= 3'd5);
                case (seg_i)
                    3'd0:    begin park_leg = LEG_A; park_high = 1'b1; end
                    3'd1:    begin park_leg = LEG_C; park_high = 1'b0; end
                    3'd2:    begin park_leg = LEG_B; park_high = 1'b1; end
                    3'd3:    begin park_leg = LEG_A; park_high = 1'b0; end
                    3'd4:    begin park_leg = LEG_C; park_high = 1'b1; end
                    default: begin park_leg = LEG_B; park_high = 1'b0; end
                endcase
            end
            MODE_UP_ENV: begin
                valid     = (seg_i <= 3'd2);
                park_high = 1'b1;
                park_leg  = (seg_i == 3'd1) ? LEG_B : (seg_i == 3'd2) ? LEG_C : LEG_A;
            end
            MODE_LOW_ENV: begin
                valid     = (seg_i <= 3'd2);
                park_high = 1'b0;
                park_leg  = (seg_i == 3'd1) ? LEG_A : (seg_i == 3'd2) ? LEG_B : LEG_C;
            end
            default: begin
                valid = 1'b0;
            end
        endcase
    end

    // Solve the upper duties of the two active legs around the parked level.
    always_comb begin
        ab   = XW'(dab_i);
        bc   = XW'(dbc_i);
        ca   = XW'(dca_i);
        lvl  = park_high ? XW'(PEAK) : '0;
        dp_raw[0] = lvl;
        dp_raw[1] = lvl;
        dp_raw[2] = lvl;
        case (park_leg)
            LEG_A: begin
                dp_raw[1] = lvl - ab;
                dp_raw[2] = lvl + ca;
            end
            LEG_B: begin
                dp_raw[0] = lvl + ab;
                dp_raw[2] = lvl - bc;
            end
            default: begin
                dp_raw[1] = lvl + bc;
                dp_raw[0] = lvl - ca;
            end
        endcase
    end

    // Clamp each active duty into the band and convert to a bottom duty.
    always_comb begin
        lo_s = $signed(XW'(lo_lim_i));
        hi_s = $signed(XW'(hi_lim_i));
    end

    for (genvar g = 0; g < 3; g++) begin : g_leg
        always_comb begin
            if (dp_raw[g] < lo_s) begin
                dp_cl[g] = lo_s;
            end else if (dp_raw[g] > hi_s) begin
                dp_cl[g] = hi_s;
            end else begin
                dp_cl[g] = dp_raw[g];
            end
            dn_o[g] = CNT_W'(XW'(PEAK) - dp_cl[g]);
            en_o[g] = valid && (park_leg != 2'(g));
        end
    end
endmodule

// File: rtl/pwm3_leg_out.sv
// One bridge leg: compares the triangle with the bottom duty and inserts dead time.
// Assumes: dn_i <= PEAK; outputs lag the compare by one registered cycle.
module pwm3_leg_out #(
    parameter  int PEAK  = 2500,
    parameter  int DT_W  = 8,
    localparam int PH_W  = $clog2(2 * PEAK),
    localparam int CNT_W = $clog2(PEAK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  ph_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] dn_i,
    input  logic [DT_W-1:0]  dt_i,
    output logic             hi_o,
    output logic             lo_o
);
    logic            rising;
    logic [PH_W-1:0] car;
    logic [PH_W-1:0] dn_w;
    logic            lo_raw;
    logic [1:0]      pat;
    logic [1:0]      pat_q;
    logic [DT_W-1:0] gap_q;
    logic [DT_W-1:0] gap_n;

    // Fold the phase into a triangle and decide the wanted gate pattern.
    always_comb begin
        rising = (ph_i < PH_W'(PEAK));
        car    = rising ? ph_i : (PH_W'(2 * PEAK) - ph_i);
        dn_w   = PH_W'(dn_i);
        lo_raw = en_i && (rising ? (car < dn_w) : (car <= dn_w));
        pat    = {en_i && !lo_raw, lo_raw};
    end

    // Restart the dead-time gap on any pattern change, otherwise count down.
    always_comb begin
        if (pat != pat_q) begin
            gap_n = dt_i;
        end else if (gap_q != '0) begin
            gap_n = gap_q - 1'b1;
        end else begin
            gap_n = '0;
        end
    end

    // Register the gates, holding both off while the gap runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= 2'b00;
            gap_q <= '0;
            hi_o  <= 1'b0;
            lo_o  <= 1'b0;
        end else begin
            pat_q <= pat;
            gap_q <= gap_n;
            {hi_o, lo_o} <= (gap_n == '0) ? pat : 2'b00;
        end
    end

    assert_no_shoot_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o));

    assert_gap_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(dt_i) != '0) && $past(lo_o)) |-> !hi_o);

    assert_gap_after_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(dt_i) != '0) && $past(hi_o)) |-> !lo_o);
endmodule

// File: rtl/pwm3_seg_bridge.sv
// Top: shadow capture at period end, segment mapping and three gated legs.
// Assumes: duty_min_i <= duty_max_i <= PEAK; dead time shorter than the shortest on-window.
module pwm3_seg_bridge
    import pwm3_pkg::*;
#(
    parameter  int PEAK  = 2500,
    parameter  int DW    = 14,
    parameter  int DT_W  = 8,
    localparam int CNT_W = $clog2(PEAK + 1),
    localparam int PH_W  = $clog2(2 * PEAK)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic [2:0]           seg_i,
    input  logic signed [DW-1:0] dab_i,
    input  logic signed [DW-1:0] dbc_i,
    input  logic signed [DW-1:0] dca_i,
    input  logic [CNT_W-1:0]     duty_min_i,
    input  logic [CNT_W-1:0]     duty_max_i,
    input  logic [DT_W-1:0]      dead_i,
    output logic [2:0]           gate_hi_o,
    output logic [2:0]           gate_lo_o,
    output logic                 adc_trig_o
);
    logic [PH_W-1:0]         ph;
    logic                    load;
    pwm_mode_e               mode_q;
    logic [2:0]              seg_q;
    logic signed [DW-1:0]    dab_q;
    logic signed [DW-1:0]    dbc_q;
    logic signed [DW-1:0]    dca_q;
    logic [CNT_W-1:0]        lo_lim_q;
    logic [CNT_W-1:0]        hi_lim_q;
    logic [DT_W-1:0]         dt_q;
    logic [2:0]              leg_en;
    logic [2:0][CNT_W-1:0]   leg_dn;

    pwm3_carrier #(.PEAK(PEAK)) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_o   (ph),
        .load_o (load),
        .trig_o (adc_trig_o)
    );

    // Capture all commands in the last cycle of the period; reset parks everything off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_OFF;
            seg_q    <= '0;
            dab_q    <= '0;
            dbc_q    <= '0;
            dca_q    <= '0;
            lo_lim_q <= '0;
            hi_lim_q <= '0;
            dt_q     <= '0;
        end else if (load) begin
            mode_q   <= pwm_mode_e'(mode_i);
            seg_q    <= seg_i;
            dab_q    <= dab_i;
            dbc_q    <= dbc_i;
            dca_q    <= dca_i;
            lo_lim_q <= duty_min_i;
            hi_lim_q <= duty_max_i;
            dt_q     <= dead_i;
        end
    end

    pwm3_seg_map #(.PEAK(PEAK), .DW(DW)) u_map (
        .mode_i   (mode_q),
        .seg_i    (seg_q),
        .dab_i    (dab_q),
        .dbc_i    (dbc_q),
        .dca_i    (dca_q),
        .lo_lim_i (lo_lim_q),
        .hi_lim_i (hi_lim_q),
        .en_o     (leg_en),
        .dn_o     (leg_dn)
    );

    for (genvar g = 0; g < 3; g++) begin : g_leg
        pwm3_leg_out #(.PEAK(PEAK), .DT_W(DT_W)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .ph_i  (ph),
            .en_i  (leg_en[g]),
            .dn_i  (leg_dn[g]),
            .dt_i  (dt_q),
            .hi_o  (gate_hi_o[g]),
            .lo_o  (gate_lo_o[g])
        );

        assert_parked_leg_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(leg_en[g]) |-> (!gate_hi_o[g] && !gate_lo_o[g]));
    end

    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> ($stable(seg_q) && $stable(mode_q) && $stable(dab_q)));
endmodule

// File: tb/pwm3_seg_bridge_tb.sv
module pwm3_seg_bridge_tb;
    localparam int P    = 20;
    localparam int DW   = 8;
    localparam int DT_W = 4;
    localparam int CW   = $clog2(P + 1);
    localparam int DMIN = 3;
    localparam int DMAX = 17;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [1:0]           mode;
    logic [2:0]           seg;
    logic signed [DW-1:0] dab;
    logic signed [DW-1:0] dbc;
    logic signed [DW-1:0] dca;
    logic [CW-1:0]        dmin;
    logic [CW-1:0]        dmax;
    logic [DT_W-1:0]      dead;
    logic [2:0]           gh;
    logic [2:0]           gl;
    logic                 trig;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwm3_seg_bridge #(.PEAK(P), .DW(DW), .DT_W(DT_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .mode_i (mode), .seg_i (seg),
        .dab_i (dab), .dbc_i (dbc), .dca_i (dca),
        .duty_min_i (dmin), .duty_max_i (dmax), .dead_i (dead),
        .gate_hi_o (gh), .gate_lo_o (gl), .adc_trig_o (trig)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wait_trig();
        do @(negedge clk); while (!trig);
    endtask

    task automatic drive(int m, int s, int a, int b, int c, int dt);
        mode = 2'(m); seg = 3'(s);
        dab = DW'(a); dbc = DW'(b); dca = DW'(c);
        dmin = CW'(DMIN); dmax = CW'(DMAX); dead = DT_W'(dt);
    endtask

    function automatic int clampi(int v);
        if (v < DMIN) return DMIN;
        if (v > DMAX) return DMAX;
        return v;
    endfunction

    // Expected parked leg (-1 for none) and active upper duties, from R3/R4/R5.
    task automatic model(int m, int s, int a, int b, int c, output int park, output int dp[3]);
        int lv;
        park = -1; lv = 0;
        if (m == 0 && s <= 5) begin
            case (s)
                0: begin park = 0; lv = P; end
                1: begin park = 2; lv = 0; end
                2: begin park = 1; lv = P; end
                3: begin park = 0; lv = 0; end
                4: begin park = 2; lv = P; end
                default: begin park = 1; lv = 0; end
            endcase
        end else if (m == 1 && s <= 2) begin
            park = s; lv = P;
        end else if (m == 2 && s <= 2) begin
            park = (s == 0) ? 2 : (s == 1) ? 0 : 1; lv = 0;
        end
        dp[0] = lv; dp[1] = lv; dp[2] = lv;
        if (park == 0) begin dp[1] = lv - a; dp[2] = lv + c; end
        if (park == 1) begin dp[0] = lv + a; dp[2] = lv - b; end
        if (park == 2) begin dp[1] = lv + b; dp[0] = lv - c; end
        for (int l = 0; l < 3; l++) dp[l] = clampi(dp[l]);
    endtask

    task automatic run_case(int m, int s, int a, int b, int c, int dt);
        int park; int dp[3]; int hc[3]; int lc[3]; int rise[3];
        int ovl; int silent; int exp_silent;
        wait_trig();
        drive(m, s, a, b, c, dt);
        wait_trig();
        model(m, s, a, b, c, park, dp);
        for (int l = 0; l < 3; l++) begin hc[l] = 0; lc[l] = 0; rise[l] = -1; end
        ovl = 0;
        wait_trig();
        for (int k = 0; k < 2 * P; k++) begin
            if (k > 0) @(negedge clk);
            for (int l = 0; l < 3; l++) begin
                if (gh[l]) hc[l]++;
                if (gl[l]) begin lc[l]++; if (rise[l] < 0) rise[l] = k; end
                if (gh[l] && gl[l]) ovl = 1;
            end
        end
        chk("R7", "both gates of a leg on together", ovl, 0);
        silent = 0;
        for (int l = 0; l < 3; l++) if (hc[l] == 0 && lc[l] == 0) silent |= (1 << l);
        if (park < 0) begin
            chk("R9", "silent-leg mask for reserved code", silent, 7);
        end else begin
            exp_silent = 1 << park;
            chk("R3", "silent-leg mask", silent, exp_silent);
            chk("R8", "parked leg gate-on cycles", hc[park] + lc[park], 0);
            for (int l = 0; l < 3; l++) begin
                if (l != park) begin
                    chk("R4", $sformatf("upper on-count leg %0d m%0d s%0d", l, m, s), hc[l], 2 * dp[l] - dt);
                    chk("R5", $sformatf("lower on-count leg %0d m%0d s%0d", l, m, s), lc[l], 2 * (P - dp[l]) - dt);
                    chk("R6", $sformatf("lower turn-on offset leg %0d", l), rise[l], dp[l] + 1 + dt);
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int bad;
        int tpos;
        int gap;
        int sets [4][3];
        sets[0] = '{5, -8, 3};
        sets[1] = '{-10, 4, 6};
        sets[2] = '{15, -30, 15};
        sets[3] = '{0, 0, 0};

        // R11: outputs low during reset even with a valid command present.
        rst_n = 1'b0;
        drive(0, 0, 5, -8, 3, 1);
        bad = 0;
        repeat (6) begin
            @(negedge clk);
            if (gh != 3'b0 || gl != 3'b0 || trig) bad++;
        end
        chk("R11", "active outputs during reset", bad, 0);
        rst_n = 1'b1;

        // R11/R2: first period all off; first strobe in cycle PEAK after release.
        bad = 0; tpos = -1;
        for (int j = 1; j < 2 * P; j++) begin
            @(negedge clk);
            if (gh != 3'b0 || gl != 3'b0) bad++;
            if (trig && tpos < 0) tpos = j;
        end
        chk("R11", "gate-on cycles in first period", bad, 0);
        chk("R2", "first strobe cycle after reset", tpos, P);

        // R1/R2: strobe spacing and width.
        wait_trig();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!trig);
        chk("R1", "cycles between strobes", gap, 2 * P);
        @(negedge clk);
        chk("R2", "strobe width", int'(trig), 0);

        // Main sweep over every valid mode/segment and four duty sets.
        for (int m = 0; m < 3; m++) begin
            for (int s = 0; s < ((m == 0) ? 6 : 3); s++) begin
                for (int d = 0; d < 4; d++) begin
                    run_case(m, s, sets[d][0], sets[d][1], sets[d][2], d);
                end
            end
        end

        // R9: reserved codes.
        run_case(3, 0, 5, -8, 3, 1);
        run_case(0, 6, 5, -8, 3, 1);
        run_case(0, 7, 5, -8, 3, 1);
        run_case(1, 3, 5, -8, 3, 1);
        run_case(2, 5, 5, -8, 3, 1);

        // R10: segment change after the strobe waits for the period boundary.
        run_case(0, 0, 5, -8, 3, 1);
        wait_trig();
        seg = 3'd2;
        begin
            int a_on; int b_hi1; int b_on_late; int a_on_late;
            a_on = 0; b_hi1 = 0; b_on_late = 0; a_on_late = 0;
            for (int k = 1; k <= 2 * P; k++) begin
                @(negedge clk);
                if (k <= P && (gh[0] || gl[0])) a_on++;
                if (k == 1) b_hi1 = int'(gh[1]);
                if (k > P && (gh[1] || gl[1])) b_on_late++;
                if (k > P && (gh[0] || gl[0])) a_on_late++;
            end
            chk("R10", "old parked leg a gate-on before boundary", a_on, 0);
            chk("R10", "leg b upper gate just after strobe", b_hi1, 1);
            chk("R10", "new parked leg b gate-on after boundary", b_on_late, 0);
            chk("R10", "leg a active after boundary", int'(a_on_late > 0), 1);
        end

        finish_run();
    end
endmodule